// File: doc/BRIEF.md
# Condition-Gated Result Commit Unit

This block sits at the end of a shader-style processor's execute stage and retires one instruction per clock. The instruction can produce two results. One is a four-component result from the vector lane. The other is a single word from the scalar lane, which is copied to all four components. The block writes these results into a bank of temporary registers, a bank of output registers, or one of two condition registers. Each component is a 32-bit IEEE-754 word. Every register is 128 bits wide: component x sits in bits [127:96], y in [95:64], z in [63:32] and w in [31:0]. In every four-bit mask, bit 3 is x and bit 0 is w.

The vector lane's write mask is the instruction's static mask ANDed with the result of a condition test. To run the test, one condition register is chosen and its components are reordered by a swizzle. Each reordered component is then classified as less than, equal to, or greater than zero. This uses only its sign bit, a zero check and a NaN check. The reserved temporary index 0x3F redirects a write to the condition register or to the output register. An optional saturation step clamps every component to [0,1] on the raw bits before the write. A combinational read port lets downstream logic read any register.

Top module: `wb_commit_unit`

## Requirements
- R1: After reset, every temporary, output and condition register reads as all zeros.
- R2: `cc_cond` encodes less-than in bit 0, equal in bit 1 and greater-than in bit 2. A component passes when any of its set relations holds against zero. Code 0 passes nothing. Code 7 passes everything, including NaN. NaN fails every other code. Negative zero counts as equal to zero.
- R3: Before the test, the condition register is reordered by `cc_swz`. Bits [7:6] choose the source for x, [5:4] for y, [3:2] for z and [1:0] for w. The selector values are 0=x, 1=y, 2=z and 3=w, so 0x1B is the identity.
- R4: `cc_sel` chooses which of the two condition registers is tested, and which one a condition-register write updates.
- R5: `vec_commit` equals `vec_mask` ANDed with the test result when `cc_test_en` is 1. It equals `vec_mask` alone when `cc_test_en` is 0, and it is 0 when `vec_we` is low. The test never affects the scalar lane.
- R6: A vector write with `vec_tidx`=0x3F and `out_flag`=0 updates only the selected condition register.
- R7: In any other case, a vector write updates output register `out_idx` when `out_flag`=1 and `out_idx`<16. It also updates temporary `vec_tidx` when that index is not 0x3F. Both writes can happen together.
- R8: A scalar write with `sca_tidx`=0x3F goes to the selected condition register when `out_flag`=1. When `out_flag`=0 it goes to output register `out_idx`, provided that index is below 16. Any other index writes that temporary.
- R9: The scalar word is copied to every component, and only the components set in `sca_mask` are written.
- R10: With `sat_en` set, every written word that has its sign bit set becomes 0x00000000. Every word with a clear sign bit and a value of 0x3F800000 or more becomes 0x3F800000. Other words are unchanged. This applies to both lanes.
- R11: If the two lanes write the same register in the same cycle, the scalar value wins on the components they share.
- R12: Writes take effect at the next rising edge. `rd_data` shows the register chosen by `rd_kind` (0 temporary, 1 output, 2 condition register `rd_idx[0]`) and `rd_idx` without any added cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_we | input | 1 | Vector lane write strobe |
| vec_data | input | 128 | Vector result |
| vec_mask | input | 4 | Static vector component mask |
| vec_tidx | input | 6 | Vector temporary index (0x3F reserved) |
| sca_we | input | 1 | Scalar lane write strobe |
| sca_data | input | 32 | Scalar result |
| sca_mask | input | 4 | Scalar component mask |
| sca_tidx | input | 6 | Scalar temporary index (0x3F reserved) |
| out_flag | input | 1 | Output-routing flag of the instruction |
| out_idx | input | 5 | Output register index |
| sat_en | input | 1 | Clamp results to [0,1] |
| cc_sel | input | 1 | Condition register select |
| cc_test_en | input | 1 | Enable the condition test |
| cc_cond | input | 3 | Relation code |
| cc_swz | input | 8 | Condition swizzle selectors |
| rd_kind | input | 2 | Read bank select |
| rd_idx | input | 6 | Read index |
| rd_data | output | 128 | Read data |
| vec_commit | output | 4 | Final vector component write mask |

## Verification
Most faults in the condition evaluator appear at once on `vec_commit`, in the same cycle as the instruction. This includes a wrong swizzle source, a wrong sign or zero decision, or a NaN that leaks through. A fault in routing or in the merge only appears one edge later, and only when the damaged register is read back. A component that is written when it should be left alone, or a write that lands in the wrong register, shows up on the first read of the affected register. Faults in a condition register can also appear indirectly, because the next gated write uses the corrupted value to build its mask.

// File: rtl/wb_pkg.sv
package wb_pkg;
    localparam int NCOMP  = 4;
    localparam int CW     = 32;
    localparam int VW     = NCOMP * CW;
    localparam int SW     = $clog2(NCOMP);

    localparam int EXP_MSB = 30;
    localparam int EXP_LSB = 23;
    localparam int MAN_MSB = 22;
    localparam logic [CW-1:0] ONE_F = 32'h3F80_0000;

    localparam int CC_LT_BIT = 0;
    localparam int CC_EQ_BIT = 1;
    localparam int CC_GT_BIT = 2;
    localparam logic [2:0] CC_ALWAYS = 3'b111;

    localparam logic [1:0] RD_TMP = 2'd0;
    localparam logic [1:0] RD_OUT = 2'd1;
    localparam logic [1:0] RD_CC  = 2'd2;

    typedef logic [VW-1:0]    vec_t;
    typedef logic [NCOMP-1:0] cmask_t;

    // Replace the components selected by m; mask bit c covers word c.
    function automatic vec_t mask_merge(input vec_t old_v, input vec_t new_v, input cmask_t m);
        vec_t r;
        r = old_v;
        for (int c = 0; c < NCOMP; c++) begin
            if (m[c]) r[c*CW +: CW] = new_v[c*CW +: CW];
        end
        return r;
    endfunction
endpackage

// File: rtl/wb_cc_eval.sv
module wb_cc_eval
    import wb_pkg::*;
(
    input  logic [VW-1:0]       cc_vec,
    input  logic [NCOMP*SW-1:0] swz,
    input  logic [2:0]          cond,
    output logic [NCOMP-1:0]    pass
);
    logic [NCOMP-1:0][CW-1:0] words;
    assign words = cc_vec;

    for (genvar p = 0; p < NCOMP; p++) begin : g_comp
        logic [SW-1:0] sel;
        logic [SW-1:0] pos;
        logic [CW-1:0] w;
        logic          is_neg, is_zero, is_nan, rel_lt, rel_eq, rel_gt;

        assign sel     = swz[p*SW +: SW];
        assign pos     = SW'(NCOMP-1) - sel;
        assign w       = words[pos];
        assign is_neg  = w[CW-1];
        assign is_zero = ~|w[CW-2:0];
        assign is_nan  = (&w[EXP_MSB:EXP_LSB]) & (|w[MAN_MSB:0]);
        assign rel_eq  = is_zero;
        assign rel_lt  = is_neg & ~is_zero & ~is_nan;
        assign rel_gt  = ~is_neg & ~is_zero & ~is_nan;
        assign pass[p] = (cond == CC_ALWAYS)
                       | (cond[CC_LT_BIT] & rel_lt)
                       | (cond[CC_EQ_BIT] & rel_eq)
                       | (cond[CC_GT_BIT] & rel_gt);
    end
endmodule

// File: rtl/wb_sat.sv
module wb_sat
    import wb_pkg::*;
(
    input  logic          en,
    input  logic [VW-1:0] din,
    output logic [VW-1:0] dout
);
    for (genvar p = 0; p < NCOMP; p++) begin : g_word
        logic [CW-1:0] w;
        assign w = din[p*CW +: CW];
        always_comb begin
            if (!en)              dout[p*CW +: CW] = w;
            else if (w[CW-1])     dout[p*CW +: CW] = '0;
            else if (w >= ONE_F)  dout[p*CW +: CW] = ONE_F;
            else                  dout[p*CW +: CW] = w;
        end
    end
endmodule

// File: rtl/wb_route.sv
module wb_route #(
    parameter int NTEMP  = 32,
    parameter int NOUT   = 16,
    parameter int TIDX_W = 6,
    parameter int OIDX_W = 5
) (
    input  logic              vec_we,
    input  logic [TIDX_W-1:0] vec_tidx,
    input  logic              sca_we,
    input  logic [TIDX_W-1:0] sca_tidx,
    input  logic              out_flag,
    input  logic [OIDX_W-1:0] out_idx,
    output logic              vec_to_cc,
    output logic              vec_to_out,
    output logic              vec_to_tmp,
    output logic              sca_to_cc,
    output logic              sca_to_out,
    output logic              sca_to_tmp
);
    localparam logic [TIDX_W-1:0] RSV     = '1;
    localparam logic [TIDX_W-1:0] TMP_LIM = TIDX_W'(NTEMP);
    localparam logic [OIDX_W-1:0] OUT_LIM = OIDX_W'(NOUT);

    logic v_rsv, s_rsv, out_ok;
    assign v_rsv  = (vec_tidx == RSV);
    assign s_rsv  = (sca_tidx == RSV);
    assign out_ok = (out_idx < OUT_LIM);

    assign vec_to_cc  = vec_we & v_rsv & ~out_flag;
    assign vec_to_out = vec_we & out_flag & out_ok;
    assign vec_to_tmp = vec_we & ~v_rsv & (vec_tidx < TMP_LIM);

    assign sca_to_cc  = sca_we & s_rsv & out_flag;
    assign sca_to_out = sca_we & s_rsv & ~out_flag & out_ok;
    assign sca_to_tmp = sca_we & ~s_rsv & (sca_tidx < TMP_LIM);
endmodule

// File: rtl/wb_commit_unit.sv
module wb_commit_unit
    import wb_pkg::*;
#(
    parameter int NTEMP  = 32,
    parameter int NOUT   = 16,
    parameter int TIDX_W = 6,
    parameter int OIDX_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vec_we,
    input  logic [VW-1:0]       vec_data,
    input  logic [NCOMP-1:0]    vec_mask,
    input  logic [TIDX_W-1:0]   vec_tidx,
    input  logic                sca_we,
    input  logic [CW-1:0]       sca_data,
    input  logic [NCOMP-1:0]    sca_mask,
    input  logic [TIDX_W-1:0]   sca_tidx,
    input  logic                out_flag,
    input  logic [OIDX_W-1:0]   out_idx,
    input  logic                sat_en,
    input  logic                cc_sel,
    input  logic                cc_test_en,
    input  logic [2:0]          cc_cond,
    input  logic [NCOMP*SW-1:0] cc_swz,
    input  logic [1:0]          rd_kind,
    input  logic [TIDX_W-1:0]   rd_idx,
    output logic [VW-1:0]       rd_data,
    output logic [NCOMP-1:0]    vec_commit
);
    localparam int TSEL_W = $clog2(NTEMP);
    localparam int OSEL_W = $clog2(NOUT);
    localparam logic [TIDX_W-1:0] RD_TLIM = TIDX_W'(NTEMP);
    localparam logic [TIDX_W-1:0] RD_OLIM = TIDX_W'(NOUT);

    typedef struct packed {
        logic [NTEMP-1:0][VW-1:0] tmp;
        logic [NOUT-1:0][VW-1:0]  outr;
        logic [1:0][VW-1:0]       cc;
    } regs_t;

    regs_t st_d, st_q;

    logic [NCOMP-1:0] cc_pass, gate;
    logic [VW-1:0]    vec_sat, sca_sat;
    logic v_cc, v_out, v_tmp, s_cc, s_out, s_tmp;
    logic [TSEL_W-1:0] v_ti, s_ti;
    logic [OSEL_W-1:0] o_i;

    wb_cc_eval i_eval (
        .cc_vec (st_q.cc[cc_sel]),
        .swz    (cc_swz),
        .cond   (cc_cond),
        .pass   (cc_pass)
    );

    wb_sat i_vsat (.en(sat_en), .din(vec_data),          .dout(vec_sat));
    wb_sat i_ssat (.en(sat_en), .din({NCOMP{sca_data}}), .dout(sca_sat));

    wb_route #(
        .NTEMP(NTEMP), .NOUT(NOUT), .TIDX_W(TIDX_W), .OIDX_W(OIDX_W)
    ) i_route (
        .vec_we    (vec_we),
        .vec_tidx  (vec_tidx),
        .sca_we    (sca_we),
        .sca_tidx  (sca_tidx),
        .out_flag  (out_flag),
        .out_idx   (out_idx),
        .vec_to_cc (v_cc),
        .vec_to_out(v_out),
        .vec_to_tmp(v_tmp),
        .sca_to_cc (s_cc),
        .sca_to_out(s_out),
        .sca_to_tmp(s_tmp)
    );

    assign gate       = cc_test_en ? cc_pass : '1;
    assign vec_commit = vec_we ? (vec_mask & gate) : '0;
    assign v_ti       = vec_tidx[TSEL_W-1:0];
    assign s_ti       = sca_tidx[TSEL_W-1:0];
    assign o_i        = out_idx[OSEL_W-1:0];

    // Next-state: vector lane first, scalar lane over it so it wins on overlap.
    always_comb begin
        st_d = st_q;
        if (v_cc)  st_d.cc[cc_sel] = mask_merge(st_d.cc[cc_sel], vec_sat, vec_commit);
        if (v_out) st_d.outr[o_i]  = mask_merge(st_d.outr[o_i],  vec_sat, vec_commit);
        if (v_tmp) st_d.tmp[v_ti]  = mask_merge(st_d.tmp[v_ti],  vec_sat, vec_commit);
        if (s_cc)  st_d.cc[cc_sel] = mask_merge(st_d.cc[cc_sel], sca_sat, sca_mask);
        if (s_out) st_d.outr[o_i]  = mask_merge(st_d.outr[o_i],  sca_sat, sca_mask);
        if (s_tmp) st_d.tmp[s_ti]  = mask_merge(st_d.tmp[s_ti],  sca_sat, sca_mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_kind)
            RD_TMP:  if (rd_idx < RD_TLIM) rd_data = st_q.tmp[rd_idx[TSEL_W-1:0]];
            RD_OUT:  if (rd_idx < RD_OLIM) rd_data = st_q.outr[rd_idx[OSEL_W-1:0]];
            RD_CC:   rd_data = st_q.cc[rd_idx[0]];
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/wb_commit_chk.sv
module wb_commit_chk
    import wb_pkg::*;
#(
    parameter int NTEMP  = 32,
    parameter int TIDX_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              vec_we,
    input logic [VW-1:0]     vec_data,
    input logic [NCOMP-1:0]  vec_mask,
    input logic [TIDX_W-1:0] vec_tidx,
    input logic              sca_we,
    input logic              sat_en,
    input logic              cc_test_en,
    input logic [2:0]        cc_cond,
    input logic [1:0]        rd_kind,
    input logic [TIDX_W-1:0] rd_idx,
    input logic [VW-1:0]     rd_data,
    input logic [NCOMP-1:0]  vec_commit
);
    localparam logic [TIDX_W-1:0] RSV  = '1;
    localparam logic [TIDX_W-1:0] TLIM = TIDX_W'(NTEMP);

    // R5
    commit_within_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_commit & ~vec_mask) == '0);

    // R5
    commit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_we |-> vec_commit == '0);

    // R2
    never_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_we && cc_test_en && cc_cond == 3'b000) |-> vec_commit == '0);

    // R2
    always_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_we && cc_test_en && cc_cond == 3'b111) |-> vec_commit == vec_mask);

    // R12
    temp_write_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(vec_we && !sca_we && !sat_en && !cc_test_en &&
           vec_mask == '1 && vec_tidx != RSV && vec_tidx < TLIM) &&
         rd_kind == RD_TMP && rd_idx == $past(vec_tidx))
        |-> rd_data == $past(vec_data));

    // R12
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(vec_we) && !$past(sca_we) &&
         $stable(rd_kind) && $stable(rd_idx)) |-> $stable(rd_data));
endmodule

bind wb_commit_unit wb_commit_chk #(.NTEMP(NTEMP), .TIDX_W(TIDX_W)) i_commit_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .vec_we     (vec_we),
    .vec_data   (vec_data),
    .vec_mask   (vec_mask),
    .vec_tidx   (vec_tidx),
    .sca_we     (sca_we),
    .sat_en     (sat_en),
    .cc_test_en (cc_test_en),
    .cc_cond    (cc_cond),
    .rd_kind    (rd_kind),
    .rd_idx     (rd_idx),
    .rd_data    (rd_data),
    .vec_commit (vec_commit)
);

// File: tb/test_wb_commit_unit.sv
`timescale 1ns/1ps
module test_wb_commit_unit;
    localparam logic [31:0] F1   = 32'h3F80_0000;
    localparam logic [31:0] F2   = 32'h4000_0000;
    localparam logic [31:0] F3   = 32'h4040_0000;
    localparam logic [31:0] FN1  = 32'hBF80_0000;
    localparam logic [31:0] FN2  = 32'hC000_0000;
    localparam logic [31:0] FH   = 32'h3F00_0000;
    localparam logic [31:0] FNZ  = 32'h8000_0000;
    localparam logic [31:0] FNAN = 32'h7FC0_0000;
    localparam logic [31:0] FINF = 32'h7F80_0000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic vec_we, sca_we, out_flag, sat_en, cc_sel, cc_test_en;
    logic [127:0] vec_data;
    logic [3:0]   vec_mask, sca_mask, vec_commit;
    logic [5:0]   vec_tidx, sca_tidx, rd_idx;
    logic [31:0]  sca_data;
    logic [4:0]   out_idx;
    logic [2:0]   cc_cond;
    logic [7:0]   cc_swz;
    logic [1:0]   rd_kind;
    logic [127:0] rd_data;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    wb_commit_unit i_wb_commit_unit (
        .clk(clk), .rst_n(rst_n),
        .vec_we(vec_we), .vec_data(vec_data), .vec_mask(vec_mask), .vec_tidx(vec_tidx),
        .sca_we(sca_we), .sca_data(sca_data), .sca_mask(sca_mask), .sca_tidx(sca_tidx),
        .out_flag(out_flag), .out_idx(out_idx), .sat_en(sat_en), .cc_sel(cc_sel),
        .cc_test_en(cc_test_en), .cc_cond(cc_cond), .cc_swz(cc_swz),
        .rd_kind(rd_kind), .rd_idx(rd_idx), .rd_data(rd_data), .vec_commit(vec_commit)
    );

    function automatic logic [127:0] v4(logic [31:0] x, logic [31:0] y, logic [31:0] z, logic [31:0] w);
        return {x, y, z, w};
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clr();
        vec_we = 0; sca_we = 0; out_flag = 0; sat_en = 0; cc_sel = 0; cc_test_en = 0;
        vec_data = '0; vec_mask = 4'hF; vec_tidx = 6'h3F; sca_data = '0; sca_mask = 4'hF;
        sca_tidx = 6'h3F; out_idx = 5'd20; cc_cond = 3'd0; cc_swz = 8'h1B;
    endtask

    task automatic step();
        @(posedge clk); #1;
        clr();
    endtask

    task automatic rd(input logic [1:0] k, input logic [5:0] idx, input logic [127:0] exp, input string tag);
        rd_kind = k; rd_idx = idx; #0.2;
        chk(tag, rd_data, exp);
    endtask

    // Probe the commit mask with no destination selected.
    task automatic probe(input logic s, input logic [2:0] c, input logic [7:0] z, input logic [3:0] exp, input string tag);
        clr(); vec_we = 1; out_flag = 1; out_idx = 5'd20; vec_tidx = 6'h3F;
        cc_test_en = 1; cc_sel = s; cc_cond = c; cc_swz = z; #0.2;
        chk(tag, {124'd0, vec_commit}, {124'd0, exp});
        clr();
    endtask

    task automatic t_reset();
        rd(0, 6'd0, '0, "R1 temp0");
        rd(0, 6'd31, '0, "R1 temp31");
        rd(1, 6'd15, '0, "R1 out15");
        rd(2, 6'd0, '0, "R1 cc0");
        rd(2, 6'd1, '0, "R1 cc1");
        chk("R5 idle commit", {124'd0, vec_commit}, '0);
    endtask

    task automatic t_vec_temp();
        clr(); vec_we = 1; vec_tidx = 6'd5; vec_data = v4(F1, F2, FN1, FH); step();
        rd(0, 6'd5, v4(F1, F2, FN1, FH), "R12 temp5 full");
        clr(); vec_we = 1; vec_tidx = 6'd5; vec_mask = 4'b1010;
        vec_data = v4(32'hA, 32'hB, 32'hC, 32'hD); #0.2;
        chk("R5 no test", {124'd0, vec_commit}, {124'd0, 4'b1010});
        step();
        rd(0, 6'd5, v4(32'hA, F2, 32'hC, FH), "R12 temp5 partial");
    endtask

    task automatic t_cond();
        clr(); vec_we = 1; vec_data = v4(FN1, 32'd0, F2, FNAN); step();
        rd(2, 6'd0, v4(FN1, 32'd0, F2, FNAN), "R6 cc0 load");
        for (int c = 0; c < 8; c++) begin
            logic [2:0] cb;
            logic [3:0] e;
            cb = 3'(c);
            e = (cb == 3'b111) ? 4'hF : {cb[0], cb[1], cb[2], 1'b0};
            probe(0, cb, 8'h1B, e, $sformatf("R2 code %0d", c));
        end
        clr(); vec_we = 1; vec_tidx = 6'd20; cc_test_en = 1; cc_cond = 3'd4;
        vec_data = v4(F1, F1, F1, F1); step();
        rd(0, 6'd20, v4(0, 0, F1, 0), "R5 gated temp20");
    endtask

    task automatic t_swz();
        probe(0, 3'd4, 8'hAA, 4'hF,    "R3 all z gt");
        probe(0, 3'd7, 8'hFF, 4'hF,    "R3 all nan always");
        probe(0, 3'd4, 8'hFF, 4'h0,    "R3 all nan gt");
        probe(0, 3'd1, 8'h05, 4'b1100, "R3 xxyy lt");
        probe(0, 3'd2, 8'hE4, 4'b0010, "R3 reverse eq");
        probe(0, 3'd1, 8'hE4, 4'b0001, "R3 reverse lt");
    endtask

    task automatic t_ccsel();
        clr(); vec_we = 1; cc_sel = 1; vec_data = v4(FNZ, F1, FN1, 0); step();
        rd(2, 6'd1, v4(FNZ, F1, FN1, 0), "R4 cc1 load");
        rd(2, 6'd0, v4(FN1, 32'd0, F2, FNAN), "R4 cc0 untouched");
        probe(1, 3'd2, 8'h1B, 4'b1001, "R4 cc1 eq incl -0");
        clr(); vec_we = 1; cc_sel = 1; cc_test_en = 1; cc_cond = 3'd2; vec_tidx = 6'd7;
        vec_data = {4{32'h1111_1111}}; step();
        rd(0, 6'd7, v4(32'h1111_1111, 0, 0, 32'h1111_1111), "R4 gated by cc1");
    endtask

    task automatic t_vec_out();
        clr(); vec_we = 1; out_flag = 1; out_idx = 5'd3; vec_tidx = 6'd9;
        vec_data = v4(32'h1, 32'h2, 32'h3, 32'h4); step();
        rd(1, 6'd3, v4(32'h1, 32'h2, 32'h3, 32'h4), "R7 out3 dual");
        rd(0, 6'd9, v4(32'h1, 32'h2, 32'h3, 32'h4), "R7 temp9 dual");
        clr(); vec_we = 1; out_flag = 1; out_idx = 5'd17; vec_data = {4{32'h5555_5555}}; step();
        rd(1, 6'd1, '0, "R7 out index 17 dropped");
        rd(2, 6'd0, v4(FN1, 32'd0, F2, FNAN), "R6 flag set keeps cc0");
        clr(); vec_we = 1; out_flag = 1; out_idx = 5'd3; vec_mask = 4'b0110;
        vec_data = {4{32'h7777_7777}}; step();
        rd(1, 6'd3, v4(32'h1, 32'h7777_7777, 32'h7777_7777, 32'h4), "R7 out3 masked");
    endtask

    task automatic t_sca();
        clr(); sca_we = 1; sca_tidx = 6'd12; sca_mask = 4'b0101; sca_data = F3; step();
        rd(0, 6'd12, v4(0, F3, 0, F3), "R9 broadcast mask");
        clr(); sca_we = 1; out_idx = 5'd4; sca_data = F2; step();
        rd(1, 6'd4, {4{F2}}, "R8 reserved to out");
        clr(); sca_we = 1; out_flag = 1; cc_sel = 1; sca_mask = 4'b1000; sca_data = F3; step();
        rd(2, 6'd1, v4(F3, F1, FN1, 0), "R8 reserved to cc1");
        clr(); vec_we = 1; vec_tidx = 6'd21; cc_test_en = 1; cc_cond = 3'd0; vec_data = {4{F1}};
        sca_we = 1; sca_tidx = 6'd22; sca_data = FH; step();
        rd(0, 6'd21, '0, "R5 vector blocked");
        rd(0, 6'd22, {4{FH}}, "R5 scalar not gated");
    endtask

    task automatic t_sat();
        clr(); sat_en = 1; vec_we = 1; vec_tidx = 6'd14; vec_data = v4(FN1, FH, F2, FNZ); step();
        rd(0, 6'd14, v4(0, FH, F1, 0), "R10 vector clamp");
        clr(); sat_en = 1; vec_we = 1; vec_tidx = 6'd14;
        vec_data = v4(FINF, 32'h3F7F_FFFF, F1, 32'hFFC0_0000); step();
        rd(0, 6'd14, v4(F1, 32'h3F7F_FFFF, F1, 0), "R10 edge words");
        clr(); sat_en = 1; sca_we = 1; sca_tidx = 6'd15; sca_data = FN2; step();
        rd(0, 6'd15, '0, "R10 scalar clamp");
    endtask

    task automatic t_overlap();
        clr(); vec_we = 1; vec_tidx = 6'd16; vec_data = v4(32'h10, 32'h20, 32'h30, 32'h40);
        sca_we = 1; sca_tidx = 6'd16; sca_mask = 4'b0011; sca_data = 32'h99; step();
        rd(0, 6'd16, v4(32'h10, 32'h20, 32'h99, 32'h99), "R11 scalar wins");
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        clr(); rd_kind = 0; rd_idx = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_vec_temp();
        t_cond();
        t_swz();
        t_ccsel();
        t_vec_out();
        t_sca();
        t_sat();
        t_overlap();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule